// File: doc/BRIEF.md
# Pipelined Read Requester for a Shared-Clock Chip-to-Chip Link

This block is the issuing end of a read link between two chips that run from one common clock. A local source offers read commands through a valid/ready pair. The block places each accepted address on a one-direction address bus and pulses a request strobe for that cycle. The far side answers in order after a fixed number of cycles. It drives a separate one-direction data bus and qualifies each word with its own strobe. The returned words leave the block on a local valid/data port, one cycle after they arrive, in the order the requests went out.

Requests do not wait for earlier answers. A credit counter tracks how many reads are in flight. A new request may go out on every cycle until the count reaches a set ceiling. A credit that is returned in a cycle can be spent in that same cycle, so a ceiling equal to the round-trip latency keeps the address bus busy on every cycle. A parameter selects a blocking variant with a ceiling of one and no same-cycle reuse. In that variant only one read is in flight at a time, and a latency of L cycles gives one request every L+1 cycles. A data strobe that arrives while nothing is outstanding is not passed on and sets a sticky error flag.

Top module: `rd_requester`

## Requirements
- R1: After reset, cmd_ready is 1, out_valid is 0, proto_err is 0 and no read is outstanding.
- R2: bus_req is 1 in a cycle exactly when cmd_valid and cmd_ready are both 1, and bus_addr then equals cmd_addr.
- R3: In pipelined mode cmd_ready is 0 only when the outstanding count equals MAX_OUT and bus_wen is 0 (or bus_wen is 1 with nothing outstanding). The count never exceeds the ceiling.
- R4: In pipelined mode, a bus_wen arriving while the count is at the ceiling lets a new request go out in that same cycle. With MAX_OUT=2 and a latency of 4, a steady command stream yields 10 requests in 20 cycles.
- R5: In blocking mode (BLOCKING=1) the ceiling is 1 and cmd_ready is 1 only when nothing is outstanding. With a latency of L=4, a steady stream yields one request every 5 cycles (4 in 20).
- R6: With MAX_OUT no smaller than the latency, a steady command stream yields a request on every cycle (20 in 20).
- R7: A bus_wen with at least one read outstanding produces out_valid=1 in the next cycle, with out_data equal to that cycle's bus_data. Words leave in request order.
- R8: A bus_wen with no read outstanding sets proto_err from the next cycle until reset, produces no out_valid and leaves the outstanding count unchanged.
- R9: The outstanding count rises by one on each issued request and falls by one on each accepted bus_wen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both chips |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Local read command offered |
| cmd_addr | input | ADDR_W | Address of the offered command |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| bus_req | output | 1 | Read-request strobe to the responder |
| bus_addr | output | ADDR_W | Read address to the responder |
| bus_wen | input | 1 | Returned word present on bus_data |
| bus_data | input | DATA_W | Returned data word |
| out_valid | output | 1 | Local returned word valid |
| out_data | output | DATA_W | Local returned word |
| proto_err | output | 1 | Sticky flag for a return with nothing outstanding |

## Verification
The hardest state to reach is the cycle in which the count sits at its ceiling and a returned word arrives at the same moment. Only in that cycle does the pipelined variant differ from the blocking one, and a slip there changes the throughput rather than any single value. The bench runs three instances side by side behind a behavioural fixed-latency responder. The first has a ceiling equal to the latency, the second has a smaller ceiling and the third is blocking. Each receives a continuous command stream, and the bench counts requests over a window aligned to whole periods. A stray return strobe is injected only after all responders have drained, so that the error path is reached with the count at zero.

// File: rtl/rdq_pkg.sv
package rdq_pkg;

    typedef enum logic [1:0] {
        RET_NONE  = 2'd0,
        RET_GOOD  = 2'd1,
        RET_STRAY = 2'd2
    } ret_kind_e;

    function automatic int unsigned credit_limit(input int unsigned max_out, input bit blocking);
        return blocking ? 1 : max_out;
    endfunction

    function automatic ret_kind_e classify_return(input logic wen, input logic none_out);
        if (!wen)
            return RET_NONE;
        else if (none_out)
            return RET_STRAY;
        else
            return RET_GOOD;
    endfunction

endpackage

// File: rtl/rdq_credit.sv
module rdq_credit #(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned CNT_W = 3,
    parameter bit          REUSE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic             ret_take,
    output logic             ready,
    output logic             none_out,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

    logic below_lim;

    assign none_out  = (count == '0);
    assign below_lim = (count < LIM_V);

    generate
        if (REUSE) begin : g_reuse
            assign ready = below_lim || ret_take;
        end else begin : g_block
            assign ready = below_lim;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case ({issue, ret_take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rdq_return.sv
module rdq_return
    import rdq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  ret_kind_e         kind,
    input  logic [DATA_W-1:0] word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            err       <= 1'b0;
        end else begin
            out_valid <= (kind == RET_GOOD);
            if (kind == RET_GOOD)
                out_data <= word;
            if (kind == RET_STRAY)
                err <= 1'b1;
        end
    end

endmodule

// File: rtl/rd_requester.sv
module rd_requester
    import rdq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned MAX_OUT  = 4,
    parameter bit          BLOCKING = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [DATA_W-1:0] bus_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              proto_err
);
    localparam int unsigned LIMIT = credit_limit(MAX_OUT, BLOCKING);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic             none_out;
    logic [CNT_W-1:0] outstanding;
    ret_kind_e        kind;

    assign kind     = classify_return(bus_wen, none_out);
    assign bus_req  = cmd_valid && cmd_ready;
    assign bus_addr = cmd_addr;

    rdq_credit #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W),
        .REUSE (!BLOCKING)
    ) u_credit (
        .clk      (clk),
        .rst      (rst),
        .issue    (bus_req),
        .ret_take (kind == RET_GOOD),
        .ready    (cmd_ready),
        .none_out (none_out),
        .count    (outstanding)
    );

    rdq_return #(
        .DATA_W (DATA_W)
    ) u_return (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .word      (bus_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .err       (proto_err)
    );

endmodule

// File: rtl/rdq_checker.sv
module rdq_checker #(
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned LIMIT    = 4,
    parameter bit          BLOCKING = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             bus_req,
    input logic             bus_wen,
    input logic             out_valid,
    input logic             proto_err,
    input logic [CNT_W-1:0] cnt
);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(LIMIT));

    a_r2_req_needs_valid: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (cmd_valid && cmd_ready));

    a_r7_out_after_return: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && cnt != '0) |=> out_valid);

    a_r8_stray_sets_err: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && cnt == '0) |=> (proto_err && !out_valid));

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    a_r9_count_up: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_wen) |=> (cnt == $past(cnt) + 1'b1));

    a_r5_blocking_single: assert property (@(posedge clk) disable iff (rst)
        (BLOCKING && cnt != '0) |-> !cmd_ready);

endmodule

bind rd_requester rdq_checker #(
    .CNT_W    (CNT_W),
    .LIMIT    (LIMIT),
    .BLOCKING (BLOCKING)
) u_rdq_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .bus_req   (bus_req),
    .bus_wen   (bus_wen),
    .out_valid (out_valid),
    .proto_err (proto_err),
    .cnt       (outstanding)
);

// File: tb/test_rd_requester.sv
`timescale 1ns/1ps
module test_rd_requester;
    localparam int NL  = 3;
    localparam int LAT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_addr  [NL];
    logic        cmd_ready [NL];
    logic        bus_req   [NL];
    logic [15:0] bus_addr  [NL];
    logic        bus_wen   [NL];
    logic [15:0] bus_data  [NL];
    logic        out_valid [NL];
    logic [15:0] out_data  [NL];
    logic        proto_err [NL];

    // lane 0: ceiling 4 = latency, lane 1: ceiling 2, lane 2: blocking
    generate
        for (genvar g = 0; g < NL; g++) begin : g_lane
            if (g == 0) begin : g_full
                rd_requester #(.MAX_OUT(4), .BLOCKING(1'b0)) i_rd_requester (
                    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr[g]),
                    .cmd_ready(cmd_ready[g]), .bus_req(bus_req[g]), .bus_addr(bus_addr[g]),
                    .bus_wen(bus_wen[g]), .bus_data(bus_data[g]), .out_valid(out_valid[g]),
                    .out_data(out_data[g]), .proto_err(proto_err[g]));
            end else if (g == 1) begin : g_half
                rd_requester #(.MAX_OUT(2), .BLOCKING(1'b0)) i_rd_requester (
                    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr[g]),
                    .cmd_ready(cmd_ready[g]), .bus_req(bus_req[g]), .bus_addr(bus_addr[g]),
                    .bus_wen(bus_wen[g]), .bus_data(bus_data[g]), .out_valid(out_valid[g]),
                    .out_data(out_data[g]), .proto_err(proto_err[g]));
            end else begin : g_blk
                rd_requester #(.MAX_OUT(4), .BLOCKING(1'b1)) i_rd_requester (
                    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr[g]),
                    .cmd_ready(cmd_ready[g]), .bus_req(bus_req[g]), .bus_addr(bus_addr[g]),
                    .bus_wen(bus_wen[g]), .bus_data(bus_data[g]), .out_valid(out_valid[g]),
                    .out_data(out_data[g]), .proto_err(proto_err[g]));
            end
        end
    endgenerate

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int          lim_m   [NL] = '{4, 2, 1};
    bit          blk_m   [NL] = '{1'b0, 1'b0, 1'b1};
    int          cnt_m   [NL];
    logic        pv      [NL][LAT];
    logic [15:0] pa      [NL][LAT];
    logic [15:0] expq    [NL][$];
    logic        exp_ov  [NL];
    logic [15:0] exp_od  [NL];
    logic        exp_err [NL];
    int          next_a  [NL];
    int          n_req   [NL];

    function automatic logic [15:0] resp_word(input logic [15:0] a);
        return a ^ 16'hC3A5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input bit vld, input bit stray);
        @(negedge clk);
        for (int k = 0; k < NL; k++) begin
            chk(out_valid[k] == exp_ov[k], "R7", "out_valid", int'(out_valid[k]), int'(exp_ov[k]));
            if (exp_ov[k])
                chk(out_data[k] == exp_od[k], "R7", "out_data order", int'(out_data[k]), int'(exp_od[k]));
            chk(proto_err[k] == exp_err[k], "R8", "proto_err", int'(proto_err[k]), int'(exp_err[k]));
        end
        cmd_valid = vld;
        for (int k = 0; k < NL; k++) begin
            cmd_addr[k] = 16'(next_a[k]);
            bus_wen[k]  = pv[k][LAT-1] | stray;
            bus_data[k] = pv[k][LAT-1] ? resp_word(pa[k][LAT-1]) : 16'hDEAD;
        end
        #1;
        for (int k = 0; k < NL; k++) begin
            bit wen = bus_wen[k];
            bit acc = wen && (cnt_m[k] > 0);
            bit er  = (cnt_m[k] < lim_m[k]) || (acc && !blk_m[k]);
            bit erq = vld && er;
            chk(cmd_ready[k] == er, blk_m[k] ? "R5" : "R3", "cmd_ready", int'(cmd_ready[k]), int'(er));
            chk(bus_req[k] == erq, "R2", "bus_req", int'(bus_req[k]), int'(erq));
            if (erq)
                chk(bus_addr[k] == 16'(next_a[k]), "R2", "bus_addr", int'(bus_addr[k]), next_a[k]);
            exp_ov[k] = acc;
            if (acc)
                exp_od[k] = resp_word(expq[k].pop_front());
            if (wen && cnt_m[k] == 0)
                exp_err[k] = 1'b1;
            // R9 reference count
            cnt_m[k] = cnt_m[k] + int'(erq) - int'(acc);
            for (int j = LAT - 1; j > 0; j--) begin
                pv[k][j] = pv[k][j-1];
                pa[k][j] = pa[k][j-1];
            end
            pv[k][0] = bus_req[k];
            pa[k][0] = bus_addr[k];
            if (erq) begin
                expq[k].push_back(16'(next_a[k]));
                next_a[k]++;
                n_req[k]++;
            end
        end
    endtask

    initial begin
        for (int k = 0; k < NL; k++) begin
            cmd_addr[k] = '0; bus_wen[k] = 1'b0; bus_data[k] = '0;
            cnt_m[k] = 0; exp_ov[k] = 1'b0; exp_od[k] = '0; exp_err[k] = 1'b0;
            next_a[k] = 16'h0100 * (k + 1); n_req[k] = 0;
            for (int j = 0; j < LAT; j++) begin pv[k][j] = 1'b0; pa[k][j] = '0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int k = 0; k < NL; k++) begin
            chk(cmd_ready[k] == 1'b1, "R1", "reset cmd_ready", int'(cmd_ready[k]), 1);
            chk(out_valid[k] == 1'b0, "R1", "reset out_valid", int'(out_valid[k]), 0);
            chk(proto_err[k] == 1'b0, "R1", "reset proto_err", int'(proto_err[k]), 0);
        end

        // steady stream, then measure over a 20-cycle window
        repeat (12) step(1'b1, 1'b0);
        for (int k = 0; k < NL; k++) n_req[k] = 0;
        repeat (20) step(1'b1, 1'b0);
        chk(n_req[0] == 20, "R6", "full-rate requests", n_req[0], 20);
        chk(n_req[1] == 10, "R4", "same-cycle reuse requests", n_req[1], 10);
        chk(n_req[2] == 4,  "R5", "blocking requests", n_req[2], 4);

        repeat (8) step(1'b0, 1'b0);
        for (int i = 0; i < 36; i++) step((i % 3) != 0, 1'b0);
        repeat (8) step(1'b0, 1'b0);
        for (int k = 0; k < NL; k++)
            chk(cnt_m[k] == 0, "R9", "drained model count", cnt_m[k], 0);

        // stray return with nothing outstanding
        step(1'b0, 1'b1);
        repeat (3) step(1'b0, 1'b0);
        for (int i = 0; i < 12; i++) step(1'b1, 1'b0);
        repeat (8) step(1'b0, 1'b0);
        for (int k = 0; k < NL; k++)
            chk(proto_err[k] == 1'b1, "R8", "sticky after traffic", int'(proto_err[k]), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule